// File: doc/BRIEF.md
# Register-Programmed Reset Watchdog Timer

This block is a watchdog timer that software runs entirely through three 8-bit registers on a simple write-strobe register port. The count register does double duty. A nonzero write arms or re-arms the timer with that many time units. A zero write disarms it. A read returns the units still left. A control register picks the time unit (seconds or minutes) and decides whether expiry also fires a short active-low pulse on a keyboard-reset line. A status register records that an expiry happened and holds per-source enables that let keyboard or mouse activity cancel the countdown.

The time base arrives as a one-cycle `tick_i` strobe, one per second, from a clock source outside the block. In minute mode an internal prescaler turns the strobes into one count step per minute. When the count runs out, `wdt_n_o` is driven low and stays low until software loads a fresh nonzero count. The expiry flag in the status register stays set until software clears it, so after the system comes back up it can read why the reset happened. The register addresses come from one parameter that selects one of three address maps.

Top module: `reset_watchdog`

## Requirements
- R1: A write of a value from 1 to 255 to the count register loads that value, and a read of the count register returns the units that remain.
- R2: A write of 0 to the count register stops the timer. The count then stays 0, `wdt_n_o` stays high, and later ticks have no effect.
- R3: In seconds mode (control bit 3 = 0), each `tick_i` strobe lowers a nonzero count by exactly one. Cycles without a strobe leave the count unchanged.
- R4: In minute mode (control bit 3 = 1), the count drops by one every `TICKS_PER_MIN` strobes, counted from the load. The default is 60.
- R5: When the count steps from 1 to 0, `wdt_n_o` goes low on that same edge. It stays low, with the count at 0, through further ticks and through writes of 0. It returns high only when a nonzero count is written.
- R6: Status bit 4 is set on expiry. Writing 0 to that bit clears it, and writing 1 to it neither sets it nor clears it. Status reads return only bits 7, 6 and 4, with all other bits reading 0.
- R7: If control bit 1 = 1 at expiry, `kbrst_n_o` goes low on the expiry edge and stays low for exactly `PULSE_CYCLES` cycles (16 by default). If control bit 1 = 0, `kbrst_n_o` stays high.
- R8: A one-cycle `kbd_evt_i` clears the count to 0 when status bit 6 or control bit 2 is set. This stop does not assert `wdt_n_o` and does not set status bit 4.
- R9: A one-cycle `mouse_evt_i` clears the count to 0 when status bit 7 is set. It does not assert `wdt_n_o`.
- R10: When its enable bit(s) are clear, a keyboard or mouse event leaves the count unchanged.
- R11: The addresses (count/control/status) are 0xF6/0xF5/0xF7 when `MAP_SEL`=0, 0xF4/0xF3/0xF7 when `MAP_SEL`=1, and 0xF1/0xF0/0xF2 when `MAP_SEL`=2. A write to any other address changes nothing, and a read of any other address returns 0.
- R12: After reset, all three registers read 0, and `wdt_n_o` and `kbrst_n_o` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe, one per second |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address for both reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| kbd_evt_i | input | 1 | Keyboard activity pulse |
| mouse_evt_i | input | 1 | Mouse activity pulse |
| wdt_n_o | output | 1 | Watchdog expiry output, active low |
| kbrst_n_o | output | 1 | Keyboard-reset pulse, active low |

## Verification
The bench aims at the boundary where the count leaves 1. A design that is off by one there would either assert `wdt_n_o` one tick late or let the count wrap to 255. It also checks that a written 0 neither releases a latched expiry nor causes one. The keyboard-reset pulse width is measured cycle by cycle, which exposes a counter that runs 15 or 17 cycles. The minute prescaler is probed at tick 59 and tick 60, which catches any drift in the prescale phase. Activity stops are tried with their enables both set and clear, which catches a stop that leaks through or one that wrongly raises the expiry flag. Writing 1 to the sticky flag must leave it unchanged, which catches a status bit that software can set by itself.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CTRL_PULSE_BIT = 1;
  localparam int unsigned CTRL_KBD_BIT   = 2;
  localparam int unsigned CTRL_MIN_BIT   = 3;
  localparam int unsigned STAT_EXP_BIT   = 4;
  localparam int unsigned STAT_KBD_BIT   = 6;
  localparam int unsigned STAT_MOUSE_BIT = 7;

  function automatic logic [7:0] cnt_addr(input int unsigned sel);
    return (sel == 2) ? 8'hF1 : (sel == 1) ? 8'hF4 : 8'hF6;
  endfunction
  function automatic logic [7:0] ctrl_addr(input int unsigned sel);
    return (sel == 2) ? 8'hF0 : (sel == 1) ? 8'hF3 : 8'hF5;
  endfunction
  function automatic logic [7:0] stat_addr(input int unsigned sel);
    return (sel == 2) ? 8'hF2 : 8'hF7;
  endfunction
endpackage

// File: rtl/wdt_unit_tick.sv
module wdt_unit_tick #(
  parameter int unsigned TICKS_PER_MIN = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic minute_i,
  input  logic clear_i,
  output logic step_o
);
  localparam int unsigned W = (TICKS_PER_MIN > 2) ? $clog2(TICKS_PER_MIN) : 1;
  localparam logic [W-1:0] LAST = W'(TICKS_PER_MIN - 1);

  logic [W-1:0] pre_q;
  logic         wrap;

  assign wrap   = (pre_q == LAST);
  assign step_o = tick_i & (~minute_i | wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clear_i)           pre_q <= '0;
    else if (tick_i && minute_i) pre_q <= wrap ? '0 : pre_q + 1'b1;
  end

  AST_MIN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (minute_i && step_o && !clear_i) |=> (pre_q == '0)); // R4
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       stop_i,
  input  logic       step_i,
  output logic [7:0] count_o,
  output logic       expire_o,
  output logic       expired_o
);
  logic [7:0] count_q;
  logic       expired_q;
  logic       run;

  assign run      = step_i & ~load_i & ~stop_i & (count_q != 8'd0);
  assign expire_o = run & (count_q == 8'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= 8'd0;
    else if (load_i) count_q <= load_val_i;
    else if (stop_i) count_q <= 8'd0;
    else if (run)    count_q <= count_q - 8'd1;
  end

  // latched expiry is released only by a nonzero load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           expired_q <= 1'b0;
    else if (load_i && load_val_i != 8'd0) expired_q <= 1'b0;
    else if (expire_o)                     expired_q <= 1'b1;
  end

  assign count_o   = count_q;
  assign expired_o = expired_q;

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_q == $past(load_val_i))); // R1
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !stop_i && step_i && count_q != 8'd0) |=> (count_q == $past(count_q) - 8'd1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !stop_i && !step_i) |=> $stable(count_q)); // R3
  AST_EXPIRED_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_q |-> (count_q == 8'd0)); // R5
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !load_i) |=> (count_q == 8'd0 && !$rose(expired_q))); // R8
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_n_o
);
  localparam int unsigned W = $clog2(PULSE_CYCLES + 1);
  localparam logic [W-1:0] LEN = W'(PULSE_CYCLES);

  logic [W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            left_q <= '0;
    else if (start_i)       left_q <= LEN;
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign pulse_n_o = (left_q == '0);

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !pulse_n_o); // R7
endmodule

// File: rtl/reset_watchdog.sv
module reset_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned MAP_SEL       = 0,
  parameter int unsigned TICKS_PER_MIN = 60,
  parameter int unsigned PULSE_CYCLES  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       kbd_evt_i,
  input  logic       mouse_evt_i,
  output logic       wdt_n_o,
  output logic       kbrst_n_o
);
  localparam logic [7:0] A_CNT  = cnt_addr(MAP_SEL);
  localparam logic [7:0] A_CTRL = ctrl_addr(MAP_SEL);
  localparam logic [7:0] A_STAT = stat_addr(MAP_SEL);

  logic [7:0] ctrl_q;
  logic       exp_flag_q, kbd_en_q, mouse_en_q;
  logic       cnt_we, ctrl_we, stat_we;
  logic       stop, step, expire, expired;
  logic [7:0] count;
  logic [7:0] stat_rd;

  assign cnt_we  = we_i & (addr_i == A_CNT);
  assign ctrl_we = we_i & (addr_i == A_CTRL);
  assign stat_we = we_i & (addr_i == A_STAT);

  assign stop = (kbd_evt_i & (ctrl_q[CTRL_KBD_BIT] | kbd_en_q)) |
                (mouse_evt_i & mouse_en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= 8'd0;
    else if (ctrl_we) ctrl_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kbd_en_q   <= 1'b0;
      mouse_en_q <= 1'b0;
    end else if (stat_we) begin
      kbd_en_q   <= wdata_i[STAT_KBD_BIT];
      mouse_en_q <= wdata_i[STAT_MOUSE_BIT];
    end
  end

  // sticky cause flag: expiry sets, only a written 0 clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 exp_flag_q <= 1'b0;
    else if (expire)                             exp_flag_q <= 1'b1;
    else if (stat_we && !wdata_i[STAT_EXP_BIT])  exp_flag_q <= 1'b0;
  end

  wdt_unit_tick #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_unit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .minute_i (ctrl_q[CTRL_MIN_BIT]),
    .clear_i  (cnt_we | stop | (count == 8'd0)),
    .step_o   (step)
  );

  wdt_down_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_we),
    .load_val_i (wdata_i),
    .stop_i     (stop),
    .step_i     (step),
    .count_o    (count),
    .expire_o   (expire),
    .expired_o  (expired)
  );

  wdt_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_kbrst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (expire & ctrl_q[CTRL_PULSE_BIT]),
    .pulse_n_o (kbrst_n_o)
  );

  assign wdt_n_o = ~expired;

  always_comb begin
    stat_rd = 8'd0;
    stat_rd[STAT_EXP_BIT]   = exp_flag_q;
    stat_rd[STAT_KBD_BIT]   = kbd_en_q;
    stat_rd[STAT_MOUSE_BIT] = mouse_en_q;
  end

  always_comb begin
    if (addr_i == A_CNT)       rdata_o = count;
    else if (addr_i == A_CTRL) rdata_o = ctrl_q;
    else if (addr_i == A_STAT) rdata_o = stat_rd;
    else                       rdata_o = 8'd0;
  end

  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_flag_q && !(stat_we && !wdata_i[STAT_EXP_BIT])) |=> exp_flag_q); // R6
  AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_n_o) |-> exp_flag_q); // R6
  AST_WDT_ONLY_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_n_o |-> (count == 8'd0)); // R5
  AST_NO_PULSE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kbrst_n_o && !(expire && ctrl_q[CTRL_PULSE_BIT])) |=> kbrst_n_o); // R7
endmodule

// File: tb/reset_watchdog_test.sv
module reset_watchdog_test;
  localparam logic [7:0] A_CNT = 8'hF6, A_CTRL = 8'hF5, A_STAT = 8'hF7;
  localparam int PULSE = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, we = 1'b0, kbd = 1'b0, mouse = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic wdt_n, kbrst_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  reset_watchdog uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .kbd_evt_i(kbd), .mouse_evt_i(mouse),
    .wdt_n_o(wdt_n), .kbrst_n_o(kbrst_n)
  );

  function automatic logic [7:0] exp_left(input int v, input int n);
    return (v > n) ? 8'(v - n) : 8'd0;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    cyc();
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(); tick = 1'b0;
    end
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R12 reset state
    chk_reg("R12 count", A_CNT, 8'h00);
    chk_reg("R12 ctrl", A_CTRL, 8'h00);
    chk_reg("R12 stat", A_STAT, 8'h00);
    check("R12 wdt_n", {7'd0, wdt_n}, 8'h01);
    check("R12 kbrst_n", {7'd0, kbrst_n}, 8'h01);

    // R1 / R3 / R2
    wr(A_CNT, 8'd5);
    chk_reg("R1 load", A_CNT, 8'd5);
    ticks(2);
    chk_reg("R3 two ticks", A_CNT, 8'd3);
    repeat (7) cyc();
    chk_reg("R3 idle hold", A_CNT, 8'd3);
    wr(A_CNT, 8'd0);
    chk_reg("R2 stop", A_CNT, 8'd0);
    ticks(10);
    chk_reg("R2 stays stopped", A_CNT, 8'd0);
    check("R2 no expiry", {7'd0, wdt_n}, 8'h01);

    // R3 random loads and tick runs
    for (int k = 0; k < 20; k++) begin
      int v, n;
      v = 1 + int'($urandom % 200);
      n = int'($urandom % v);
      wr(A_CNT, 8'(v));
      ticks(n);
      repeat (int'($urandom % 4)) cyc();
      chk_reg("R3 random countdown", A_CNT, exp_left(v, n));
      check("R3 random not expired", {7'd0, wdt_n}, 8'h01);
    end

    // R5 / R6 / R7 expiry with pulse
    wr(A_CTRL, 8'h02);
    chk_reg("R1 ctrl readback", A_CTRL, 8'h02);
    wr(A_CNT, 8'd3);
    ticks(2);
    check("R5 before expiry", {7'd0, wdt_n}, 8'h01);
    check("R7 no early pulse", {7'd0, kbrst_n}, 8'h01);
    ticks(1);
    check("R5 expiry edge", {7'd0, wdt_n}, 8'h00);
    chk_reg("R6 flag set", A_STAT, 8'h10);
    check("R7 pulse low", {7'd0, kbrst_n}, 8'h00);
    for (int i = 1; i < PULSE; i++) begin
      cyc();
      check("R7 pulse still low", {7'd0, kbrst_n}, 8'h00);
    end
    cyc();
    check("R7 pulse ended", {7'd0, kbrst_n}, 8'h01);
    ticks(3);
    chk_reg("R5 count held at 0", A_CNT, 8'h00);
    check("R5 output held", {7'd0, wdt_n}, 8'h00);
    wr(A_CNT, 8'd0);
    check("R5 zero write keeps low", {7'd0, wdt_n}, 8'h00);
    wr(A_STAT, 8'h10);
    chk_reg("R6 write 1 keeps flag", A_STAT, 8'h10);
    wr(A_STAT, 8'h00);
    chk_reg("R6 write 0 clears", A_STAT, 8'h00);
    wr(A_STAT, 8'h10);
    chk_reg("R6 write 1 cannot set", A_STAT, 8'h00);
    wr(A_STAT, 8'h2F);
    chk_reg("R6 unused status bits", A_STAT, 8'h00);
    wr(A_CNT, 8'd7);
    check("R5 released by load", {7'd0, wdt_n}, 8'h01);

    // R7 no pulse when disabled
    wr(A_CTRL, 8'h00);
    wr(A_CNT, 8'd1);
    ticks(1);
    check("R5 expiry from 1", {7'd0, wdt_n}, 8'h00);
    for (int i = 0; i < 20; i++) begin
      check("R7 disabled no pulse", {7'd0, kbrst_n}, 8'h01);
      cyc();
    end

    // R4 minute mode
    wr(A_CTRL, 8'h08);
    wr(A_CNT, 8'd2);
    ticks(59);
    chk_reg("R4 tick 59", A_CNT, 8'd2);
    ticks(1);
    chk_reg("R4 tick 60", A_CNT, 8'd1);
    ticks(59);
    check("R4 not yet expired", {7'd0, wdt_n}, 8'h01);
    ticks(1);
    chk_reg("R4 minute expiry", A_CNT, 8'd0);
    check("R4 minute wdt low", {7'd0, wdt_n}, 8'h00);

    // R8 / R9 / R10 activity stops
    wr(A_CTRL, 8'h00);
    wr(A_STAT, 8'h00);
    wr(A_CNT, 8'd9);
    kbd = 1'b1; cyc(); kbd = 1'b0;
    chk_reg("R10 kbd ignored", A_CNT, 8'd9);
    mouse = 1'b1; cyc(); mouse = 1'b0;
    chk_reg("R10 mouse ignored", A_CNT, 8'd9);
    wr(A_STAT, 8'h40);
    chk_reg("R8 kbd enable readback", A_STAT, 8'h40);
    mouse = 1'b1; cyc(); mouse = 1'b0;
    chk_reg("R10 mouse ignored with kbd enable", A_CNT, 8'd9);
    kbd = 1'b1; cyc(); kbd = 1'b0;
    chk_reg("R8 kbd stop via status", A_CNT, 8'd0);
    check("R8 no wdt", {7'd0, wdt_n}, 8'h01);
    chk_reg("R8 no flag", A_STAT, 8'h40);
    wr(A_STAT, 8'h00);
    wr(A_CTRL, 8'h04);
    wr(A_CNT, 8'd9);
    kbd = 1'b1; cyc(); kbd = 1'b0;
    chk_reg("R8 kbd stop via control", A_CNT, 8'd0);
    wr(A_CTRL, 8'h00);
    wr(A_STAT, 8'h80);
    wr(A_CNT, 8'd9);
    kbd = 1'b1; cyc(); kbd = 1'b0;
    chk_reg("R10 kbd ignored with mouse enable", A_CNT, 8'd9);
    mouse = 1'b1; cyc(); mouse = 1'b0;
    chk_reg("R9 mouse stop", A_CNT, 8'd0);
    check("R9 no wdt", {7'd0, wdt_n}, 8'h01);
    chk_reg("R9 no flag", A_STAT, 8'h80);

    // R11 foreign address
    wr(A_CNT, 8'd4);
    wr(8'h55, 8'hFF);
    wr(8'hF4, 8'hFF);
    chk_reg("R11 count untouched", A_CNT, 8'd4);
    chk_reg("R11 ctrl untouched", A_CTRL, 8'h00);
    chk_reg("R11 stat untouched", A_STAT, 8'h80);
    chk_reg("R11 foreign read", 8'h55, 8'h00);
    rd(8'hF1, d);
    check("R11 other map read", d, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule